// File: doc/BRIEF.md
# Masked Interrupt Status Unit

This block gathers eight interrupt status bits for a serial communications controller and drives one active-low interrupt request line. Some bits follow level inputs from the transmitter, the receiver and the counter/timer. Two bits are sticky event flags: one is raised by a change of a general-purpose input pin and one by the start or end of a received break. Each sticky flag is cleared by its own reset-command pulse. One more bit holds the pin level, captured when a status read begins.

An 8-bit mask register selects which status bits may pull the interrupt line low. The mask only gates the interrupt line. The status vector presented for CPU reads is always the unmasked value. The pin is asynchronous, so it passes through a synchronizer before edge detection. The sources themselves and the bus decoding are outside this block; they appear here only as input signals.

Top module: `irq_status_unit`

## Requirements
- R1: `irq_n` is low exactly when some bit of `status_q` AND the matching bit of `mask_q` are both 1. It is registered, so it follows the status and mask values one clock edge later.
- R2: `status_q` does not depend on the mask. A status bit set while its mask bit is 0 still reads 1, and `irq_n` stays high.
- R3: Bit 7 (pin change) is set when the synchronized pin changes level. It is visible three clock edges after the pin changes, and it stays set until a `clr_pin_chg` pulse.
- R4: Bit 6 (pin level) loads the synchronized pin level on each edge where `rd_strobe` is 1, and holds its value otherwise.
- R5: Bit 3 (break change) is set one edge after a `brk_edge` pulse and cleared one edge after a `clr_brk_chg` pulse.
- R6: Bit 1 follows `tx_empty` and bit 0 follows `tx_ready`, each one clock edge later.
- R7: Bit 4 follows `cnt_ready` and bit 2 follows `rx_ready_full`, each one clock edge later.
- R8: While `rst` is high at a clock edge, `status_q` and `mask_q` become 0 and `irq_n` becomes 1.
- R9: Bit 5 is reserved and always reads 0.
- R10: When a set event and the clear command for the same sticky bit arrive in the same cycle, the bit ends up set.
- R11: A pin level that is already present when reset is released does not set bit 7.
- R12: A `mask_wr` pulse loads `mask_wdata` into `mask_q` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gp_in | input | 1 | Asynchronous general-purpose input pin |
| tx_ready | input | 1 | Transmitter ready level |
| tx_empty | input | 1 | Transmitter empty level |
| rx_ready_full | input | 1 | Receiver ready or FIFO-full level |
| cnt_ready | input | 1 | Counter/timer ready level |
| brk_edge | input | 1 | Pulse when a break starts or ends |
| clr_pin_chg | input | 1 | Command pulse that clears bit 7 |
| clr_brk_chg | input | 1 | Command pulse that clears bit 3 |
| rd_strobe | input | 1 | Start of a status read; captures the pin level |
| mask_wr | input | 1 | Mask register write enable |
| mask_wdata | input | 8 | Mask write data |
| status_q | output | 8 | Unmasked status vector |
| mask_q | output | 8 | Current mask register |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The mirrored bits, the break flag, both clear commands, the pin-level capture and mask writes all take effect one clock edge after the input is sampled. A pin change reaches bit 7 on the third edge, because it crosses two synchronizer stages and one edge-detect stage. `irq_n` trails the status and mask it depends on by one further edge. The bench keeps a cycle-based reference model with these same delays, updated on rising edges. It drives the inputs and compares all outputs on falling edges, so each result is read in the cycle its latency places it.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int STAT_W = 8;

  // Bit positions of the status vector (software decodes these).
  localparam int B_TX_RDY  = 0;
  localparam int B_TX_EMT  = 1;
  localparam int B_RX_RDY  = 2;
  localparam int B_BRK_CHG = 3;
  localparam int B_CNT_RDY = 4;
  localparam int B_RSVD    = 5;
  localparam int B_PIN_LVL = 6;
  localparam int B_PIN_CHG = 7;

  // Sticky flag slots inside the sticky bank.
  localparam int STK_PIN = 0;
  localparam int STK_BRK = 1;
  localparam int STK_N   = 2;

  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/irq_pin_tracker.sv
module irq_pin_tracker #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_async,
  input  logic rd_latch,
  output logic pin_change,
  output logic pin_level_q
);
  localparam int ARM_W = $clog2(SYNC_STAGES + 2);
  localparam logic [ARM_W-1:0] ARM_LAST = ARM_W'(SYNC_STAGES + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [ARM_W-1:0]       arm_cnt;
  logic                   armed;

  // Synchronizer chain; stage 0 faces the asynchronous pin.
  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[SYNC_STAGES-1];
  end

  // Edge detection waits until the chain and the history flop hold real pin samples.
  always_ff @(posedge clk) begin
    if (rst)                  arm_cnt <= '0;
    else if (arm_cnt != ARM_LAST) arm_cnt <= arm_cnt + 1'b1;
  end
  assign armed = (arm_cnt == ARM_LAST);

  assign pin_change = armed && (sync_q[SYNC_STAGES-1] != prev_q);

  always_ff @(posedge clk) begin
    if (rst)           pin_level_q <= 1'b0;
    else if (rd_latch) pin_level_q <= sync_q[SYNC_STAGES-1];
  end
endmodule

// File: rtl/irq_sticky_cell.sv
module irq_sticky_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic clr_cmd,
  output logic flag_q
);
  // A set in the same cycle as a clear wins.
  always_ff @(posedge clk) begin
    if (rst)          flag_q <= 1'b0;
    else if (set_ev)  flag_q <= 1'b1;
    else if (clr_cmd) flag_q <= 1'b0;
  end
endmodule

// File: rtl/irq_mask_gate.sv
module irq_mask_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] status,
  output logic [W-1:0] mask_q,
  output logic         irq_n
);
  always_ff @(posedge clk) begin
    if (rst)        mask_q <= '0;
    else if (wr_en) mask_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(status & mask_q);
  end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gp_in,
  input  logic              tx_ready,
  input  logic              tx_empty,
  input  logic              rx_ready_full,
  input  logic              cnt_ready,
  input  logic              brk_edge,
  input  logic              clr_pin_chg,
  input  logic              clr_brk_chg,
  input  logic              rd_strobe,
  input  logic              mask_wr,
  input  logic [STAT_W-1:0] mask_wdata,
  output logic [STAT_W-1:0] status_q,
  output logic [STAT_W-1:0] mask_q,
  output logic              irq_n
);
  localparam int MIR_N = 4;

  logic             pin_change;
  logic             pin_level_q;
  logic [STK_N-1:0] stk_set;
  logic [STK_N-1:0] stk_clr;
  logic [STK_N-1:0] stk_q;
  logic [MIR_N-1:0] mir_d;
  logic [MIR_N-1:0] mir_q;
  stat_t            stat_vec;

  irq_pin_tracker #(.SYNC_STAGES(SYNC_STAGES)) pin_i (
    .clk        (clk),
    .rst        (rst),
    .pin_async  (gp_in),
    .rd_latch   (rd_strobe),
    .pin_change (pin_change),
    .pin_level_q(pin_level_q)
  );

  assign stk_set[STK_PIN] = pin_change;
  assign stk_clr[STK_PIN] = clr_pin_chg;
  assign stk_set[STK_BRK] = brk_edge;
  assign stk_clr[STK_BRK] = clr_brk_chg;

  for (genvar k = 0; k < STK_N; k++) begin : g_stk
    irq_sticky_cell cell_i (
      .clk    (clk),
      .rst    (rst),
      .set_ev (stk_set[k]),
      .clr_cmd(stk_clr[k]),
      .flag_q (stk_q[k])
    );
  end

  // Level-following sources, registered once.
  assign mir_d = {cnt_ready, rx_ready_full, tx_empty, tx_ready};
  always_ff @(posedge clk) begin
    if (rst) mir_q <= '0;
    else     mir_q <= mir_d;
  end

  always_comb begin
    stat_vec            = '0;
    stat_vec[B_TX_RDY]  = mir_q[0];
    stat_vec[B_TX_EMT]  = mir_q[1];
    stat_vec[B_RX_RDY]  = mir_q[2];
    stat_vec[B_CNT_RDY] = mir_q[3];
    stat_vec[B_BRK_CHG] = stk_q[STK_BRK];
    stat_vec[B_PIN_CHG] = stk_q[STK_PIN];
    stat_vec[B_PIN_LVL] = pin_level_q;
    stat_vec[B_RSVD]    = 1'b0;
  end
  assign status_q = stat_vec;

  irq_mask_gate #(.W(STAT_W)) gate_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (mask_wr),
    .wdata (mask_wdata),
    .status(stat_vec),
    .mask_q(mask_q),
    .irq_n (irq_n)
  );
endmodule

// File: rtl/irq_status_checker.sv
module irq_status_checker (
  input logic       clk,
  input logic       rst,
  input logic       tx_ready,
  input logic       tx_empty,
  input logic       rx_ready_full,
  input logic       cnt_ready,
  input logic       brk_edge,
  input logic       clr_pin_chg,
  input logic       clr_brk_chg,
  input logic       rd_strobe,
  input logic       mask_wr,
  input logic [7:0] mask_wdata,
  input logic [7:0] status_q,
  input logic [7:0] mask_q,
  input logic       irq_n
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  assert_irq_level_R1: assert property (@(posedge clk) disable iff (rst || !armed)
    !rst |=> irq_n == ~|($past(status_q) & $past(mask_q)));

  assert_chg_hold_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    (!rst && status_q[7] && !clr_pin_chg) |=> status_q[7]);

  assert_lvl_hold_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    (!rst && !rd_strobe) |=> $stable(status_q[6]));

  assert_brk_set_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (!rst && brk_edge) |=> status_q[3]);

  assert_brk_clr_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    (!rst && clr_brk_chg && !brk_edge) |=> !status_q[3]);

  assert_tx_mirror_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    !rst |=> status_q[1:0] == $past({tx_empty, tx_ready}));

  assert_src_mirror_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    !rst |=> {status_q[4], status_q[2]} == $past({cnt_ready, rx_ready_full}));

  assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    status_q[5] == 1'b0);

  assert_set_wins_R10: assert property (@(posedge clk) disable iff (rst || !armed)
    (!rst && brk_edge && clr_brk_chg) |=> status_q[3]);

  assert_mask_load_R12: assert property (@(posedge clk) disable iff (rst || !armed)
    (!rst && mask_wr) |=> mask_q == $past(mask_wdata));
endmodule

bind irq_status_unit irq_status_checker chk_i (
  .clk          (clk),
  .rst          (rst),
  .tx_ready     (tx_ready),
  .tx_empty     (tx_empty),
  .rx_ready_full(rx_ready_full),
  .cnt_ready    (cnt_ready),
  .brk_edge     (brk_edge),
  .clr_pin_chg  (clr_pin_chg),
  .clr_brk_chg  (clr_brk_chg),
  .rd_strobe    (rd_strobe),
  .mask_wr      (mask_wr),
  .mask_wdata   (mask_wdata),
  .status_q     (status_q),
  .mask_q       (mask_q),
  .irq_n        (irq_n)
);

// File: tb/irq_status_unit_tb_top.sv
module irq_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;
  localparam int RAND_CYCLES = 4000;

  logic       clk = 1'b0;
  logic       rst, gp_in, tx_ready, tx_empty, rx_ready_full, cnt_ready;
  logic       brk_edge, clr_pin_chg, clr_brk_chg, rd_strobe, mask_wr;
  logic [7:0] mask_wdata, status_q, mask_q;
  logic       irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit dut_i (
    .clk(clk), .rst(rst), .gp_in(gp_in), .tx_ready(tx_ready), .tx_empty(tx_empty),
    .rx_ready_full(rx_ready_full), .cnt_ready(cnt_ready), .brk_edge(brk_edge),
    .clr_pin_chg(clr_pin_chg), .clr_brk_chg(clr_brk_chg), .rd_strobe(rd_strobe),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .status_q(status_q),
    .mask_q(mask_q), .irq_n(irq_n)
  );

  // Reference model built from the requirement latencies.
  logic [7:0] e_st, e_mask;
  logic       e_irq;
  logic       h1, h2, h3;
  int         quiet;

  always @(posedge clk) begin
    if (rst) begin
      e_st <= '0; e_mask <= '0; e_irq <= 1'b1;
      h1 <= 1'b0; h2 <= 1'b0; h3 <= 1'b0; quiet <= 0;
    end else begin
      h1 <= gp_in; h2 <= h1; h3 <= h2;
      if (quiet < 3) quiet <= quiet + 1;
      e_st[0] <= tx_ready;
      e_st[1] <= tx_empty;
      e_st[2] <= rx_ready_full;
      e_st[4] <= cnt_ready;
      e_st[5] <= 1'b0;
      e_st[3] <= brk_edge | (e_st[3] & ~clr_brk_chg);
      e_st[7] <= ((quiet == 3) && (h2 != h3)) | (e_st[7] & ~clr_pin_chg);
      if (rd_strobe) e_st[6] <= h2;
      if (mask_wr) e_mask <= mask_wdata;
      e_irq <= ~|(e_st & e_mask);
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pick(logic [7:0] v, int a, int b);
    return {6'd0, v[a], v[b]};
  endfunction

  task automatic compare_all();
    chk("R6 tx mirror bits",      pick(status_q, 1, 0), pick(e_st, 1, 0));
    chk("R7 cnt/rx mirror bits",  pick(status_q, 4, 2), pick(e_st, 4, 2));
    chk("R5 break change bit",    {7'd0, status_q[3]}, {7'd0, e_st[3]});
    chk("R3 pin change bit",      {7'd0, status_q[7]}, {7'd0, e_st[7]});
    chk("R4 pin level bit",       {7'd0, status_q[6]}, {7'd0, e_st[6]});
    chk("R9 reserved bit",        {7'd0, status_q[5]}, 8'd0);
    chk("R12 mask register",      mask_q, e_mask);
    chk("R1 interrupt line",      {7'd0, irq_n}, {7'd0, e_irq});
  endtask

  task automatic idle_inputs();
    brk_edge = 0; clr_pin_chg = 0; clr_brk_chg = 0; rd_strobe = 0; mask_wr = 0;
  endtask

  task automatic cycle();
    @(negedge clk);
    compare_all();
    idle_inputs();
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_2691);
    rst = 1; gp_in = 1; tx_ready = 0; tx_empty = 0; rx_ready_full = 0; cnt_ready = 0;
    mask_wdata = 8'h00; idle_inputs();
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 status after reset", status_q, 8'h00);
    chk("R8 mask after reset",   mask_q,   8'h00);
    chk("R8 irq_n after reset",  {7'd0, irq_n}, 8'd1);
    rst = 0;
    // R11: pin held high across reset release
    repeat (6) cycle();
    chk("R11 no change flag from level at reset", {7'd0, status_q[7]}, 8'd0);

    // R2: unmasked status with mask zero
    brk_edge = 1; cycle();
    chk("R2 status shows break bit with mask 0", {7'd0, status_q[3]}, 8'd1);
    cycle();
    chk("R2 irq_n stays high with mask 0", {7'd0, irq_n}, 8'd1);

    // R1: enable the break bit in the mask
    mask_wr = 1; mask_wdata = 8'h08; cycle();
    chk("R12 mask loaded", mask_q, 8'h08);
    cycle();
    chk("R1 irq_n low with masked-in bit", {7'd0, irq_n}, 8'd0);

    // R10: set and clear together
    brk_edge = 1; clr_brk_chg = 1; cycle();
    chk("R10 set wins over clear", {7'd0, status_q[3]}, 8'd1);
    clr_brk_chg = 1; cycle();
    chk("R5 break bit cleared", {7'd0, status_q[3]}, 8'd0);

    // R3: pin change, three edges to appear
    gp_in = 0; cycle(); cycle();
    chk("R3 change not yet visible", {7'd0, status_q[7]}, 8'd0);
    cycle();
    chk("R3 change visible on third edge", {7'd0, status_q[7]}, 8'd1);
    rd_strobe = 1; cycle();
    chk("R4 latched pin level", {7'd0, status_q[6]}, 8'd0);

    // Constrained random phase
    for (int i = 0; i < RAND_CYCLES; i++) begin
      if (i == RAND_CYCLES/2) begin
        rst = 1; cycle(); cycle(); rst = 0;
      end
      if ($urandom_range(0, 7) == 0) gp_in = ~gp_in;
      tx_ready      = 1'($urandom_range(0, 1));
      tx_empty      = 1'($urandom_range(0, 1));
      rx_ready_full = 1'($urandom_range(0, 1));
      cnt_ready     = 1'($urandom_range(0, 1));
      brk_edge      = ($urandom_range(0, 9) == 0);
      clr_brk_chg   = ($urandom_range(0, 7) == 0);
      clr_pin_chg   = ($urandom_range(0, 7) == 0);
      rd_strobe     = ($urandom_range(0, 5) == 0);
      mask_wr       = ($urandom_range(0, 9) == 0);
      mask_wdata    = 8'($urandom);
      cycle();
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule